// File: doc/BRIEF.md
# Opcode-Dispatch Microprogram Sequencer

This block steps the control store of a microcoded processor. It keeps a registered microprogram address, picks the next address from a small set of micro-operations chosen by a select field of the current microword, and holds a four-entry return stack for microcode subroutines. The address it drives reads a 512-word sequence ROM. The ROM itself lies outside the block.

At the end of an instruction fetch, the raw opcode byte goes straight to two places in the same cycle. It forms the next sequence address in the upper half of the sequence ROM, which holds the first microword of that instruction. It also indexes a separate 256-word decode ROM. The word that ROM returns is captured into a register once per instruction and holds the fixed ALU and register controls for the rest of the instruction. No static decoder sits between the opcode and either ROM.

The sequencer changes state only on clock edges where the cycle timer flags the end of the current micro-cycle.

Top module: `useq_top`

## Requirements
- R1: After reset, the sequence address is 0, the decode control word is 0 and the return stack is empty.
- R2: While `cyc_done` is low, the sequence address, the decode control word and the return stack do not change, whatever the other inputs are.
- R3: Select code 1 (fetch-dispatch) sets the next sequence address to 256 + opcode, which is the opcode with a 1 placed above its MSB.
- R4: Select code 0 (increment), and the unused codes 6 and 7, set the next address to the current address + 1, modulo 512.
- R5: Select code 2 (jump) loads the next address from `br_addr`.
- R6: Select code 3 (conditional branch) loads `br_addr` when `cond_in` is 1, and current address + 1 when it is 0.
- R7: Select code 4 (call) loads `br_addr` and pushes the current address + 1 onto the return stack.
- R8: Select code 5 (return) loads the most recently pushed address that has not yet been popped. Returns pop in last-in, first-out order.
- R9: The return stack holds 4 entries. A push onto a full stack overwrites the oldest entry. Afterwards, four returns yield the four newest entries.
- R10: A return from an empty stack sets the next address to 0, and the stack stays empty.
- R11: `dec_addr` always equals the current opcode. The decode control word loads `dec_rom_data` only on an advancing fetch-dispatch cycle, and otherwise keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_done | input | 1 | End-of-micro-cycle strobe; state advances only when it is high |
| opcode | input | 8 | Opcode byte coming from the fetch path |
| cond_in | input | 1 | Test condition for the conditional branch |
| br_addr | input | 9 | Branch/call target taken from the current microword |
| op_sel | input | 3 | Next-address operation select taken from the current microword |
| dec_rom_data | input | 32 | Read data of the decode ROM |
| seq_addr | output | 9 | Registered sequence ROM address |
| dec_addr | output | 8 | Decode ROM address (the opcode) |
| dec_word | output | 32 | Registered decode control word |

## Verification
Fetch-dispatch is swept across all 256 opcodes. Each opcode is given a decode ROM word that is distinct and computed, so a wrong dispatch bit or a misrouted decode index shows up as a mismatch. Increment is driven across the 511-to-0 wrap. The conditional branch is tried with both condition values from several addresses, which separates a taken branch from a fall-through. Call and return are run in a nested pattern to check LIFO order, then past four levels to expose the overwrite of the oldest entry and the zero address returned by an empty stack. Cycles with `cyc_done` low carry active jump, call and fetch selects, so any state change that leaks through is caught.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [2:0] {
    UOP_INC   = 3'd0,
    UOP_FETCH = 3'd1,
    UOP_JMP   = 3'd2,
    UOP_BCC   = 3'd3,
    UOP_CALL  = 3'd4,
    UOP_RET   = 3'd5
  } useq_op_e;
endpackage

// File: rtl/useq_stack.sv
module useq_stack #(
  parameter int AW    = 9,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_data,
  output logic [AW-1:0] pop_data,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0] wr_ptr;
  logic [CW-1:0] fill;
  logic [AW-1:0] entry [DEPTH];
  logic [PW-1:0] top_idx;
  logic          full;

  function automatic logic [PW-1:0] ptr_up(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] ptr_down(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign empty    = (fill == '0);
  assign full     = (fill == CW'(DEPTH));
  assign top_idx  = ptr_down(wr_ptr);
  assign pop_data = empty ? '0 : entry[top_idx];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_entry
      always_ff @(posedge clk) begin
        if (!rst_n)
          entry[gi] <= '0;
        else if (push && wr_ptr == PW'(gi))
          entry[gi] <= push_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      fill   <= '0;
    end else if (push) begin
      wr_ptr <= ptr_up(wr_ptr);
      if (!full) fill <= fill + 1'b1;
    end else if (pop && !empty) begin
      wr_ptr <= top_idx;
      fill   <= fill - 1'b1;
    end
  end

  p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));
  p_push_grows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full) |=> (fill == $past(fill) + 1'b1));
  p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> empty);
endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
  import useq_pkg::*;
#(
  parameter int AW  = 9,
  parameter int OPW = 8
) (
  input  logic [2:0]     op_sel,
  input  logic [AW-1:0]  cur_addr,
  input  logic [OPW-1:0] opcode,
  input  logic [AW-1:0]  br_addr,
  input  logic           cond_in,
  input  logic [AW-1:0]  ret_addr,
  output logic [AW-1:0]  next_addr,
  output logic [AW-1:0]  link_addr,
  output logic           want_push,
  output logic           want_pop,
  output logic           is_fetch,
  output logic           take_branch
);
  useq_op_e op;
  assign op = useq_op_e'(op_sel);

  function automatic logic [AW-1:0] inc_addr(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [AW-1:0] dispatch_addr(input logic [OPW-1:0] o);
    return {1'b1, o};
  endfunction

  assign link_addr   = inc_addr(cur_addr);
  assign is_fetch    = (op == UOP_FETCH);
  assign want_push   = (op == UOP_CALL);
  assign want_pop    = (op == UOP_RET);
  assign take_branch = (op == UOP_JMP) || (op == UOP_CALL) ||
                       ((op == UOP_BCC) && cond_in);

  always_comb begin
    case (op)
      UOP_FETCH: next_addr = dispatch_addr(opcode);
      UOP_RET:   next_addr = ret_addr;
      UOP_JMP, UOP_CALL, UOP_BCC:
        next_addr = take_branch ? br_addr : link_addr;
      default:   next_addr = link_addr;
    endcase
  end
endmodule

// File: rtl/useq_dec_latch.sv
module useq_dec_latch #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end

  p_dec_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(dout));
endmodule

// File: rtl/useq_top.sv
module useq_top #(
  parameter int OPW       = 8,
  parameter int DW        = 32,
  parameter int STK_DEPTH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cyc_done,
  input  logic [OPW-1:0] opcode,
  input  logic           cond_in,
  input  logic [OPW:0]   br_addr,
  input  logic [2:0]     op_sel,
  input  logic [DW-1:0]  dec_rom_data,
  output logic [OPW:0]   seq_addr,
  output logic [OPW-1:0] dec_addr,
  output logic [DW-1:0]  dec_word
);
  localparam int AW = OPW + 1;

  logic [AW-1:0] next_addr, link_addr, ret_addr;
  logic want_push, want_pop, is_fetch, take_branch;
  logic push_evt, pop_evt, dec_load, stk_empty;

  useq_nextaddr #(.AW(AW), .OPW(OPW)) u_next (
    .op_sel(op_sel), .cur_addr(seq_addr), .opcode(opcode),
    .br_addr(br_addr), .cond_in(cond_in), .ret_addr(ret_addr),
    .next_addr(next_addr), .link_addr(link_addr),
    .want_push(want_push), .want_pop(want_pop),
    .is_fetch(is_fetch), .take_branch(take_branch)
  );

  assign push_evt = cyc_done && want_push;
  assign pop_evt  = cyc_done && want_pop;
  assign dec_load = cyc_done && is_fetch;

  useq_stack #(.AW(AW), .DEPTH(STK_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push_evt), .pop(pop_evt),
    .push_data(link_addr), .pop_data(ret_addr), .empty(stk_empty)
  );

  useq_dec_latch #(.DW(DW)) u_dec (
    .clk(clk), .rst_n(rst_n), .load(dec_load),
    .din(dec_rom_data), .dout(dec_word)
  );

  assign dec_addr = opcode;

  always_ff @(posedge clk) begin
    if (!rst_n)        seq_addr <= '0;
    else if (cyc_done) seq_addr <= next_addr;
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_done |=> $stable(seq_addr));
  p_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && op_sel == 3'd1) |=> (seq_addr == {1'b1, $past(opcode)}));
  p_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && op_sel == 3'd2) |=> (seq_addr == $past(br_addr)));
  p_bcc_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && op_sel == 3'd3 && cond_in) |=> (seq_addr == $past(br_addr)));
  p_empty_ret_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && op_sel == 3'd5 && stk_empty) |=> (seq_addr == '0));
  p_no_branch_on_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_fetch |-> !take_branch);
endmodule

// File: tb/useq_top_tb_top.sv
module useq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_done = 1'b0;
  logic [7:0]  opcode = '0;
  logic        cond_in = 1'b0;
  logic [8:0]  br_addr = '0;
  logic [2:0]  op_sel = '0;
  logic [31:0] dec_rom_data;
  logic [8:0]  seq_addr;
  logic [7:0]  dec_addr;
  logic [31:0] dec_word;

  logic [31:0] dec_rom [256];
  int checks = 0;
  int fails  = 0;

  logic [8:0]  m_addr;
  logic [31:0] m_dec;
  logic [8:0]  m_stk [4];
  int          m_cnt;

  always #4 clk = ~clk;

  useq_top dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_done(cyc_done), .opcode(opcode),
    .cond_in(cond_in), .br_addr(br_addr), .op_sel(op_sel),
    .dec_rom_data(dec_rom_data), .seq_addr(seq_addr),
    .dec_addr(dec_addr), .dec_word(dec_word)
  );

  assign dec_rom_data = dec_rom[dec_addr];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, update model, compare
  task automatic step(input string req, input logic [2:0] op, input logic [7:0] opc,
                      input logic [8:0] br, input logic c, input logic done);
    logic [8:0] n;
    op_sel = op; opcode = opc; br_addr = br; cond_in = c; cyc_done = done;
    n = m_addr;
    if (done) begin
      case (op)
        3'd1: begin n = 9'd256 + 9'(opc); m_dec = dec_rom[opc]; end
        3'd2: n = br;
        3'd3: n = c ? br : m_addr + 9'd1;
        3'd4: begin
          for (int k = 3; k > 0; k--) m_stk[k] = m_stk[k-1];
          m_stk[0] = m_addr + 9'd1;
          if (m_cnt < 4) m_cnt++;
          n = br;
        end
        3'd5: begin
          if (m_cnt == 0) n = 9'd0;
          else begin
            n = m_stk[0];
            for (int k = 0; k < 3; k++) m_stk[k] = m_stk[k+1];
            m_cnt--;
          end
        end
        default: n = m_addr + 9'd1;
      endcase
    end
    m_addr = n;
    @(negedge clk);
    check(req, 32'(seq_addr), 32'(m_addr));
    check(req, dec_word, m_dec);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++)
      dec_rom[i] = (32'(i) * 32'h0101_0101) ^ 32'h5A00_00C3;
    m_addr = '0; m_dec = '0; m_cnt = 0;
    for (int k = 0; k < 4; k++) m_stk[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    check("R1 addr", 32'(seq_addr), 0);
    check("R1 dec", dec_word, 0);
    step("R1 R10 empty return after reset", 3'd5, 8'h00, 9'h1AA, 1'b0, 1'b1);

    // R3, R11: full opcode sweep
    for (int i = 0; i < 256; i++) begin
      step("R3 R11 fetch-dispatch", 3'd1, 8'(i), 9'(i ^ 9'h0F0), 1'b1, 1'b1);
      check("R11 dec_addr follows opcode", 32'(dec_addr), 32'(i));
    end

    // R2: no advance without cyc_done
    step("R5 setup", 3'd2, 8'h10, 9'h123, 1'b0, 1'b1);
    step("R2 hold jump", 3'd2, 8'h11, 9'h0AB, 1'b1, 1'b0);
    step("R2 hold fetch", 3'd1, 8'h7E, 9'h0AB, 1'b1, 1'b0);
    step("R2 hold call", 3'd4, 8'h7E, 9'h0CD, 1'b1, 1'b0);
    step("R2 R10 return sees no push", 3'd5, 8'h7E, 9'h0CD, 1'b1, 1'b1);

    // R4: increment with wrap, spare codes
    step("R5 jump", 3'd2, 8'h33, 9'd509, 1'b0, 1'b1);
    step("R4 inc", 3'd0, 8'h34, 9'h000, 1'b0, 1'b1);
    step("R4 inc", 3'd0, 8'h35, 9'h000, 1'b0, 1'b1);
    step("R4 inc wrap", 3'd0, 8'h36, 9'h000, 1'b0, 1'b1);
    step("R4 code6", 3'd6, 8'h37, 9'h1FF, 1'b1, 1'b1);
    step("R4 code7", 3'd7, 8'h38, 9'h1FF, 1'b1, 1'b1);

    // R5, R6
    for (int j = 0; j < 8; j++) begin
      step("R5 jump", 3'd2, 8'(j), 9'(j * 61 + 7), 1'b0, 1'b1);
      step("R6 branch not taken", 3'd3, 8'(j), 9'(j * 17 + 300), 1'b0, 1'b1);
      step("R6 branch taken", 3'd3, 8'(j), 9'(j * 29 + 100), 1'b1, 1'b1);
    end

    // R7, R8: nesting
    step("R5 jump", 3'd2, 8'h00, 9'h040, 1'b0, 1'b1);
    step("R7 call", 3'd4, 8'h00, 9'h080, 1'b0, 1'b1);
    step("R4 inc", 3'd0, 8'h00, 9'h000, 1'b0, 1'b1);
    step("R7 nested call", 3'd4, 8'h00, 9'h0C0, 1'b0, 1'b1);
    step("R8 return inner", 3'd5, 8'h00, 9'h1FF, 1'b1, 1'b1);
    step("R8 return outer", 3'd5, 8'h00, 9'h1FF, 1'b1, 1'b1);
    check("R8 outer lands after first call", 32'(seq_addr), 32'h041);

    // R9, R10: overflow then drain
    for (int j = 0; j < 5; j++)
      step("R9 call", 3'd4, 8'h00, 9'(16 * j + 200), 1'b0, 1'b1);
    for (int j = 0; j < 4; j++)
      step("R9 return after overflow", 3'd5, 8'h00, 9'h000, 1'b0, 1'b1);
    step("R10 return from empty", 3'd5, 8'h00, 9'h155, 1'b1, 1'b1);
    check("R10 empty gives zero", 32'(seq_addr), 0);
    step("R10 second empty return", 3'd5, 8'h00, 9'h155, 1'b1, 1'b1);

    summary();
    $finish;
  end
endmodule